// File: doc/BRIEF.md
# Effective Address and Branch Cycle Sequencer

This block produces the bus address stream for the address-forming part of an 8-bit processor with a 16-bit address space. It covers six kinds of access. Absolute indexed access adds the index to the low byte first and fixes up the page later. Zero-page indexed access wraps inside page zero. Pointer fetches never carry into the next page. Stack pushes and pulls use the fixed stack page. Taken branches add a signed offset to the PC. Interrupt vector fetches read a low byte and then a high byte. For every bus cycle the block drives one address and says whether the cycle is a read or a write. It also flags reads whose data is thrown away (dummy reads).

A command is presented on a valid/ready port. `cmd_ready` is high only while the sequencer is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The command must stay stable while `cmd_valid` waits for `cmd_ready`. The sequencer cannot absorb a command while busy, so that wait is the only back-pressure. `seq_done` pulses in the cycle in which the last bus cycle of the sequence is issued. In that same cycle `seq_pc` carries the resolved branch PC. `seq_sp` always shows the stack pointer as updated by the sequence. `bus_hold` models a ready line: while it is high, a pending read is held back and writes still go ahead.

Top module: `eff_addr_seq`

## Requirements
- R1: `cmd_ready` is 1 only while idle; a command is accepted on an edge with `cmd_valid`=1 and `cmd_ready`=1. Its first bus cycle appears in the next cycle, and `cmd_ready` returns to 1 in the cycle after `seq_done`.
- R2: `cmd_mode`=0 is absolute indexed. The index is `cmd_y` when `cmd_use_y`=1, else `cmd_x`. `cmd_acc` selects the access: 0 read, 1 read-modify-write, 2 store. For a read without a page cross, exactly one real read is issued at base+index.
- R3: In absolute indexed mode, a page cross or an access of 1 or 2 first issues a dummy read at {base high byte, low byte + index mod 256}. The real access follows at the full 16-bit sum, and it is a write when `cmd_acc`=2.
- R4: `cmd_mode`=1 is zero-page indexed. It issues a dummy read at {0x00, base low byte}, then the access at {0x00, (base low + index) mod 256}.
- R5: `cmd_mode`=2 is a pointer fetch. It issues a real read at the base P, then a real read at {P high byte, (P low + 1) mod 256}.
- R6: `cmd_mode`=3 (push) writes at 0x0100 | S and then decrements S. `cmd_mode`=4 (pull) increments S and reads at the new 0x0100 | S. Both start from `cmd_sp` and report the result on `seq_sp`.
- R7: `cmd_mode`=5 is a branch, with the offset taken from `cmd_base[7:0]`. When not taken it issues no bus cycle and gives `seq_pc`=`cmd_pc`. When taken it issues a dummy read at the PC, and on a page cross a second dummy read at {PC high, target low}. It gives `seq_pc`= PC + sign-extended offset.
- R8: `cmd_mode`=6 is a vector fetch: real reads at V, then V+1. `cmd_vsel` 0 gives V=0xFFFA, 1 gives 0xFFFC, 2 gives 0xFFFE. `cmd_vsel` 3 (software break) gives 0xFFFE, or 0xFFFA when `cmd_nmi_pend`=1.
- R9: While `bus_hold`=1 and the current cycle is a read, `bus_rd` is 0, the address holds, and the sequence does not advance. A write cycle issues regardless of `bus_hold`.
- R10: After reset, `cmd_ready`=1 and `bus_rd`, `bus_wr`, `bus_dummy` and `seq_done` are 0.
- R11: `bus_rd` and `bus_wr` are never both 1, and `bus_dummy` is 1 only together with `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_mode | input | 3 | Addressing kind (see R2 to R8) |
| cmd_acc | input | 2 | Access type for indexed modes |
| cmd_use_y | input | 1 | Select Y instead of X as index |
| cmd_vsel | input | 2 | Vector source |
| cmd_base | input | 16 | Base address, pointer, or branch offset in low byte |
| cmd_x | input | 8 | X index value |
| cmd_y | input | 8 | Y index value |
| cmd_sp | input | 8 | Stack pointer value |
| cmd_pc | input | 16 | PC after the branch operand |
| cmd_cond | input | 1 | Branch condition is true |
| cmd_nmi_pend | input | 1 | Non-maskable interrupt pending |
| bus_hold | input | 1 | Ready line: holds pending reads |
| bus_addr | output | 16 | Bus address of the current cycle |
| bus_rd | output | 1 | Read issued this cycle |
| bus_wr | output | 1 | Write issued this cycle |
| bus_dummy | output | 1 | Issued read is discarded |
| seq_done | output | 1 | Last cycle of the sequence issued |
| seq_sp | output | 8 | Stack pointer after the sequence |
| seq_pc | output | 16 | Resolved branch PC, valid with seq_done |

## Verification
The bound checker enforces the cycle invariants on every clock. These are read/write exclusion, dummy reads being reads, no read leaking out while the ready line is held, the address freezing during a hold, the stack page and zero page confinement of their modes, the stack pointer stepping after a push, and the idle return after completion. The exact address order of each mode cannot be shown by those invariants. The bench scenarios show it: the half-formed address on a page cross, the zero-page wrap, the pointer staying in its page, the branch target and its extra cycle, vector selection including the break redirect, and that writes pass a held ready line.

// File: rtl/eas_pkg.sv
package eas_pkg;
  localparam int EAS_AW = 16;
  localparam int EAS_DW = 8;

  typedef enum logic [2:0] {
    MD_ABS_IDX = 3'd0,
    MD_ZP_IDX  = 3'd1,
    MD_PTR     = 3'd2,
    MD_PUSH    = 3'd3,
    MD_PULL    = 3'd4,
    MD_BRANCH  = 3'd5,
    MD_VECTOR  = 3'd6
  } mode_e;

  typedef enum logic [1:0] {
    AC_READ  = 2'd0,
    AC_RMW   = 2'd1,
    AC_STORE = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    VS_NMI = 2'd0,
    VS_RST = 2'd1,
    VS_IRQ = 2'd2,
    VS_BRK = 2'd3
  } vsrc_e;
endpackage

// File: rtl/eas_addr_math.sv
module eas_addr_math #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] idx,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] idx_part,
  output logic [AW-1:0] idx_full,
  output logic          idx_cross,
  output logic [AW-1:0] zp_base,
  output logic [AW-1:0] zp_addr,
  output logic [AW-1:0] ptr_hi,
  output logic [AW-1:0] br_target,
  output logic [AW-1:0] br_part,
  output logic          br_cross
);
  localparam int HW = AW - DW;

  logic [DW:0]   lo_sum;
  logic [DW-1:0] ptr_lo_next;
  logic [DW-1:0] off;

  always_comb begin
    lo_sum      = {1'b0, base[DW-1:0]} + {1'b0, idx};
    ptr_lo_next = base[DW-1:0] + DW'(1);
    off         = base[DW-1:0];

    // low byte first, high byte only repaired by the full sum
    idx_part  = {base[AW-1:DW], lo_sum[DW-1:0]};
    idx_full  = base + AW'(idx);
    idx_cross = lo_sum[DW];

    zp_base = {{HW{1'b0}}, base[DW-1:0]};
    zp_addr = {{HW{1'b0}}, lo_sum[DW-1:0]};

    // pointer high-byte fetch stays inside the pointer's page
    ptr_hi = {base[AW-1:DW], ptr_lo_next};

    br_target = pc + {{HW{off[DW-1]}}, off};
    br_part   = {pc[AW-1:DW], br_target[DW-1:0]};
    br_cross  = (br_target[AW-1:DW] != pc[AW-1:DW]);
  end
endmodule

// File: rtl/eas_stack_ptr.sv
module eas_stack_ptr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          push_step,
  input  logic          pull_step,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] sp_up
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (load) begin
      sp <= load_val;
    end else if (push_step) begin
      sp <= sp - DW'(1);
    end else if (pull_step) begin
      sp <= sp + DW'(1);
    end
  end

  assign sp_up = sp + DW'(1);
endmodule

// File: rtl/eas_ready_gate.sv
module eas_ready_gate (
  input  logic active,
  input  logic hold,
  input  logic want_rd,
  input  logic want_wr,
  input  logic want_dummy,
  output logic issue,
  output logic rd,
  output logic wr,
  output logic dummy
);
  logic blocked;

  always_comb begin
    // only reads are stopped by the ready line
    blocked = hold & want_rd;
    issue   = active & ~blocked;
    rd      = active & want_rd & ~hold;
    wr      = active & want_wr & ~want_rd;
    dummy   = rd & want_dummy;
  end
endmodule

// File: rtl/eff_addr_seq.sv
module eff_addr_seq
  import eas_pkg::*;
#(
  parameter int AW = EAS_AW,
  parameter int DW = EAS_DW,
  parameter logic [AW-DW-1:0] STACK_PAGE = (AW-DW)'(1),
  parameter logic [AW-1:0] VEC_NMI = {AW{1'b1}} - AW'(5),
  parameter logic [AW-1:0] VEC_RST = {AW{1'b1}} - AW'(3),
  parameter logic [AW-1:0] VEC_IRQ = {AW{1'b1}} - AW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_mode,
  input  logic [1:0]    cmd_acc,
  input  logic          cmd_use_y,
  input  logic [1:0]    cmd_vsel,
  input  logic [AW-1:0] cmd_base,
  input  logic [DW-1:0] cmd_x,
  input  logic [DW-1:0] cmd_y,
  input  logic [DW-1:0] cmd_sp,
  input  logic [AW-1:0] cmd_pc,
  input  logic          cmd_cond,
  input  logic          cmd_nmi_pend,
  input  logic          bus_hold,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_dummy,
  output logic          seq_done,
  output logic [DW-1:0] seq_sp,
  output logic [AW-1:0] seq_pc
);
  // command registers
  logic          busy_q;
  logic          step_q;
  mode_e         mode_q;
  acc_e          acc_q;
  vsrc_e         vsel_q;
  logic [AW-1:0] base_q;
  logic [DW-1:0] idx_q;
  logic [AW-1:0] pc_q;
  logic          cond_q;
  logic          nmi_q;

  logic accept;
  assign cmd_ready = ~busy_q;
  assign accept    = cmd_valid & cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_ABS_IDX;
      acc_q  <= AC_READ;
      vsel_q <= VS_NMI;
      base_q <= '0;
      idx_q  <= '0;
      pc_q   <= '0;
      cond_q <= 1'b0;
      nmi_q  <= 1'b0;
    end else if (accept) begin
      mode_q <= mode_e'(cmd_mode);
      acc_q  <= acc_e'(cmd_acc);
      vsel_q <= vsrc_e'(cmd_vsel);
      base_q <= cmd_base;
      idx_q  <= cmd_use_y ? cmd_y : cmd_x;
      pc_q   <= cmd_pc;
      cond_q <= cmd_cond;
      nmi_q  <= cmd_nmi_pend;
    end
  end

  // address arithmetic
  logic [AW-1:0] idx_part, idx_full, zp_base, zp_addr, ptr_hi, br_target, br_part;
  logic          idx_cross, br_cross;

  eas_addr_math #(.AW(AW), .DW(DW)) math_i (
    .base      (base_q),
    .idx       (idx_q),
    .pc        (pc_q),
    .idx_part  (idx_part),
    .idx_full  (idx_full),
    .idx_cross (idx_cross),
    .zp_base   (zp_base),
    .zp_addr   (zp_addr),
    .ptr_hi    (ptr_hi),
    .br_target (br_target),
    .br_part   (br_part),
    .br_cross  (br_cross)
  );

  // vector base selection; a pending NMI takes over a break
  logic [AW-1:0] vec_lo;
  always_comb begin
    case (vsel_q)
      VS_NMI:  vec_lo = VEC_NMI;
      VS_RST:  vec_lo = VEC_RST;
      VS_IRQ:  vec_lo = VEC_IRQ;
      default: vec_lo = nmi_q ? VEC_NMI : VEC_IRQ;
    endcase
  end

  // stack pointer
  logic [DW-1:0] sp_now, sp_up;
  logic          issue;

  eas_stack_ptr #(.DW(DW)) sp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_val  (cmd_sp),
    .push_step (issue & busy_q & (mode_q == MD_PUSH)),
    .pull_step (issue & busy_q & (mode_q == MD_PULL)),
    .sp        (sp_now),
    .sp_up     (sp_up)
  );

  // per-cycle plan of the current step
  logic [AW-1:0] s_addr;
  logic          s_rd, s_wr, s_dmy, s_last;
  logic          fix_first;
  logic          acc_wr;

  always_comb begin
    acc_wr    = (acc_q == AC_STORE);
    fix_first = idx_cross | (acc_q != AC_READ);
    s_addr    = '0;
    s_rd      = 1'b0;
    s_wr      = 1'b0;
    s_dmy     = 1'b0;
    s_last    = 1'b1;
    case (mode_q)
      MD_ABS_IDX: begin
        if (!step_q && fix_first) begin
          s_addr = idx_part; s_rd = 1'b1; s_dmy = 1'b1; s_last = 1'b0;
        end else begin
          s_addr = idx_full; s_rd = ~acc_wr; s_wr = acc_wr;
        end
      end
      MD_ZP_IDX: begin
        if (!step_q) begin
          s_addr = zp_base; s_rd = 1'b1; s_dmy = 1'b1; s_last = 1'b0;
        end else begin
          s_addr = zp_addr; s_rd = ~acc_wr; s_wr = acc_wr;
        end
      end
      MD_PTR: begin
        s_rd   = 1'b1;
        s_addr = step_q ? ptr_hi : base_q;
        s_last = step_q;
      end
      MD_PUSH: begin
        s_addr = {STACK_PAGE, sp_now}; s_wr = 1'b1;
      end
      MD_PULL: begin
        s_addr = {STACK_PAGE, sp_up}; s_rd = 1'b1;
      end
      MD_BRANCH: begin
        if (cond_q) begin
          s_rd   = 1'b1;
          s_dmy  = 1'b1;
          s_addr = step_q ? br_part : pc_q;
          s_last = step_q | ~br_cross;
        end
      end
      MD_VECTOR: begin
        s_rd   = 1'b1;
        s_addr = step_q ? (vec_lo + AW'(1)) : vec_lo;
        s_last = step_q;
      end
      default: ;
    endcase
  end

  eas_ready_gate gate_i (
    .active     (busy_q),
    .hold       (bus_hold),
    .want_rd    (s_rd),
    .want_wr    (s_wr),
    .want_dummy (s_dmy),
    .issue      (issue),
    .rd         (bus_rd),
    .wr         (bus_wr),
    .dummy      (bus_dummy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      step_q <= 1'b0;
    end else if (issue) begin
      if (s_last) begin
        busy_q <= 1'b0;
        step_q <= 1'b0;
      end else begin
        step_q <= 1'b1;
      end
    end
  end

  assign bus_addr = busy_q ? s_addr : '0;
  assign seq_done = issue & s_last;
  assign seq_sp   = sp_now;
  assign seq_pc   = cond_q ? br_target : pc_q;
endmodule

// File: rtl/eas_checker.sv
module eas_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          bus_hold,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_dummy,
  input logic          seq_done,
  input logic [DW-1:0] seq_sp,
  input logic [2:0]    mode_q
);
  logic stack_mode;
  logic active_bus;
  assign stack_mode = (mode_q == 3'd3) || (mode_q == 3'd4);
  assign active_bus = bus_rd || bus_wr;

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R11
  AST_DUMMY_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dummy |-> bus_rd); // R11
  AST_HOLD_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold |-> !bus_rd); // R9
  AST_HOLD_FREEZES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && bus_hold && !bus_wr && !seq_done) |=> $stable(bus_addr)); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> cmd_ready); // R1
  AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && stack_mode && active_bus) |-> (bus_addr[AW-1:DW] == (AW-DW)'(1))); // R6
  AST_PUSH_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && mode_q == 3'd3 && bus_wr) |=> (seq_sp == $past(seq_sp) - DW'(1))); // R6
  AST_ZP_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && mode_q == 3'd1 && active_bus) |-> (bus_addr[AW-1:DW] == '0)); // R4
endmodule

bind eff_addr_seq eas_checker #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .bus_hold  (bus_hold),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_dummy (bus_dummy),
  .seq_done  (seq_done),
  .seq_sp    (seq_sp),
  .mode_q    (mode_q)
);

// File: tb/eff_addr_seq_tb_top.sv
`timescale 1ns/1ps
module eff_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_mode = '0;
  logic [1:0]  cmd_acc = '0;
  logic        cmd_use_y = 1'b0;
  logic [1:0]  cmd_vsel = '0;
  logic [15:0] cmd_base = '0;
  logic [7:0]  cmd_x = '0;
  logic [7:0]  cmd_y = '0;
  logic [7:0]  cmd_sp = '0;
  logic [15:0] cmd_pc = '0;
  logic        cmd_cond = 1'b0;
  logic        cmd_nmi_pend = 1'b0;
  logic        bus_hold = 1'b0;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr, bus_dummy, seq_done;
  logic [7:0]  seq_sp;
  logic [15:0] seq_pc;

  always #4 clk = ~clk;

  eff_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_acc(cmd_acc), .cmd_use_y(cmd_use_y), .cmd_vsel(cmd_vsel),
    .cmd_base(cmd_base), .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_sp(cmd_sp), .cmd_pc(cmd_pc),
    .cmd_cond(cmd_cond), .cmd_nmi_pend(cmd_nmi_pend), .bus_hold(bus_hold),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dummy(bus_dummy),
    .seq_done(seq_done), .seq_sp(seq_sp), .seq_pc(seq_pc)
  );

  int n_chk = 0;
  int n_err = 0;

  // trace record: kind 0 real read, 1 dummy read, 2 write
  logic [15:0] tr_addr [4];
  int          tr_kind [4];
  int          n_tr;
  bit          got_done;
  bit          r11_bad;
  bit          busy_seen_ready;
  logic [15:0] done_pc;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic set_cmd(input int mode, input int acc, input bit use_y, input int vsel,
                         input logic [15:0] base, input logic [7:0] x, input logic [7:0] y,
                         input logic [7:0] sp, input logic [15:0] pc, input bit cond, input bit nmi);
    cmd_mode = 3'(mode); cmd_acc = 2'(acc); cmd_use_y = use_y; cmd_vsel = 2'(vsel);
    cmd_base = base; cmd_x = x; cmd_y = y; cmd_sp = sp; cmd_pc = pc;
    cmd_cond = cond; cmd_nmi_pend = nmi;
  endtask

  // called at a falling edge; returns at the falling edge of the done cycle
  task automatic run_trace();
    n_tr = 0; got_done = 0; r11_bad = 0; busy_seen_ready = 0; done_pc = '0;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (cmd_ready) busy_seen_ready = 1;
      if (bus_rd && bus_wr) r11_bad = 1;
      if (bus_dummy && !bus_rd) r11_bad = 1;
      if (bus_rd || bus_wr) begin
        if (n_tr < 4) begin
          tr_addr[n_tr] = bus_addr;
          tr_kind[n_tr] = bus_wr ? 2 : (bus_dummy ? 1 : 0);
        end
        n_tr++;
      end
      if (seq_done) begin
        got_done = 1;
        done_pc = seq_pc;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_trace(input string tag, input int n_exp,
                              input logic [15:0] a0, input int k0,
                              input logic [15:0] a1, input int k1);
    chk(got_done, {tag, " done seen"}, 32'(got_done), 1);
    chk(n_tr == n_exp, {tag, " bus cycle count"}, 32'(n_tr), 32'(n_exp));
    if (n_exp >= 1 && n_tr >= 1)
      chk(tr_addr[0] == a0 && tr_kind[0] == k0, {tag, " cycle0 addr/kind"},
          {tr_addr[0], 16'(tr_kind[0])}, {a0, 16'(k0)});
    if (n_exp >= 2 && n_tr >= 2)
      chk(tr_addr[1] == a1 && tr_kind[1] == k1, {tag, " cycle1 addr/kind"},
          {tr_addr[1], 16'(tr_kind[1])}, {a1, 16'(k1)});
    chk(!r11_bad, {tag, " R11 qualifier consistency"}, 32'(r11_bad), 0);
    chk(!busy_seen_ready, {tag, " R1 ready low while busy"}, 32'(busy_seen_ready), 0);
    @(negedge clk);
    chk(cmd_ready, {tag, " R1 ready after done"}, 32'(cmd_ready), 1);
  endtask

  task automatic t_reset();
    chk(cmd_ready && !bus_rd && !bus_wr && !bus_dummy && !seq_done, "R10 reset outputs",
        {27'd0, cmd_ready, bus_rd, bus_wr, bus_dummy, seq_done}, 32'h10);
  endtask

  task automatic t_abs_idx();
    set_cmd(0, 0, 0, 0, 16'h12F0, 8'h05, 8'h00, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R2 abs read no cross", 1, 16'h12F5, 0, 16'h0, 0);
    set_cmd(0, 0, 0, 0, 16'h12F0, 8'h20, 8'h00, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R3 abs read page cross", 2, 16'h1210, 1, 16'h1310, 0);
    set_cmd(0, 2, 0, 0, 16'h2000, 8'h10, 8'h00, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R3 abs store no cross", 2, 16'h2010, 1, 16'h2010, 2);
    set_cmd(0, 1, 1, 0, 16'h20FF, 8'h77, 8'h01, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R3 abs rmw via Y cross", 2, 16'h2000, 1, 16'h2100, 0);
  endtask

  task automatic t_zp();
    set_cmd(1, 0, 0, 0, 16'h00F0, 8'h20, 8'h00, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R4 zp read wraps", 2, 16'h00F0, 1, 16'h0010, 0);
    set_cmd(1, 2, 1, 0, 16'h0040, 8'h00, 8'h03, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R4 zp store via Y", 2, 16'h0040, 1, 16'h0043, 2);
  endtask

  task automatic t_ptr();
    set_cmd(2, 0, 0, 0, 16'h30FF, 8'h00, 8'h00, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R5 pointer page end", 2, 16'h30FF, 0, 16'h3000, 0);
    set_cmd(2, 0, 0, 0, 16'h4410, 8'h00, 8'h00, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R5 pointer mid page", 2, 16'h4410, 0, 16'h4411, 0);
  endtask

  task automatic t_stack();
    set_cmd(3, 0, 0, 0, 16'h0, 8'h00, 8'h00, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R6 push at S=00", 1, 16'h0100, 2, 16'h0, 0);
    chk(seq_sp == 8'hFF, "R6 S after push", 32'(seq_sp), 32'hFF);
    set_cmd(4, 0, 0, 0, 16'h0, 8'h00, 8'h00, 8'hFF, 16'h0, 0, 0); run_trace();
    expect_trace("R6 pull at S=FF", 1, 16'h0100, 0, 16'h0, 0);
    chk(seq_sp == 8'h00, "R6 S after pull", 32'(seq_sp), 32'h00);
    set_cmd(4, 0, 0, 0, 16'h0, 8'h00, 8'h00, 8'h7F, 16'h0, 0, 0); run_trace();
    expect_trace("R6 pull at S=7F", 1, 16'h0180, 0, 16'h0, 0);
    chk(seq_sp == 8'h80, "R6 S after second pull", 32'(seq_sp), 32'h80);
  endtask

  task automatic t_branch();
    logic [15:0] pc_seen;
    set_cmd(5, 0, 0, 0, 16'h0010, 8'h00, 8'h00, 8'h00, 16'h1234, 0, 0); run_trace();
    pc_seen = done_pc;
    expect_trace("R7 not taken", 0, 16'h0, 0, 16'h0, 0);
    chk(pc_seen == 16'h1234, "R7 not taken pc", 32'(pc_seen), 32'h1234);
    set_cmd(5, 0, 0, 0, 16'h0010, 8'h00, 8'h00, 8'h00, 16'h1234, 1, 0); run_trace();
    pc_seen = done_pc;
    expect_trace("R7 taken same page", 1, 16'h1234, 1, 16'h0, 0);
    chk(pc_seen == 16'h1244, "R7 taken pc", 32'(pc_seen), 32'h1244);
    set_cmd(5, 0, 0, 0, 16'h00F0, 8'h00, 8'h00, 8'h00, 16'h1205, 1, 0); run_trace();
    pc_seen = done_pc;
    expect_trace("R7 taken back cross", 2, 16'h1205, 1, 16'h12F5, 1);
    chk(pc_seen == 16'h11F5, "R7 back cross pc", 32'(pc_seen), 32'h11F5);
    set_cmd(5, 0, 0, 0, 16'h0020, 8'h00, 8'h00, 8'h00, 16'h12F0, 1, 0); run_trace();
    pc_seen = done_pc;
    expect_trace("R7 taken forward cross", 2, 16'h12F0, 1, 16'h1210, 1);
    chk(pc_seen == 16'h1310, "R7 forward cross pc", 32'(pc_seen), 32'h1310);
  endtask

  task automatic t_vector();
    set_cmd(6, 0, 0, 0, 16'h0, 8'h00, 8'h00, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R8 nmi vector", 2, 16'hFFFA, 0, 16'hFFFB, 0);
    set_cmd(6, 0, 0, 1, 16'h0, 8'h00, 8'h00, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R8 reset vector", 2, 16'hFFFC, 0, 16'hFFFD, 0);
    set_cmd(6, 0, 0, 2, 16'h0, 8'h00, 8'h00, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R8 irq vector", 2, 16'hFFFE, 0, 16'hFFFF, 0);
    set_cmd(6, 0, 0, 3, 16'h0, 8'h00, 8'h00, 8'h00, 16'h0, 0, 0); run_trace();
    expect_trace("R8 break vector", 2, 16'hFFFE, 0, 16'hFFFF, 0);
    set_cmd(6, 0, 0, 3, 16'h0, 8'h00, 8'h00, 8'h00, 16'h0, 0, 1); run_trace();
    expect_trace("R8 break taken over by nmi", 2, 16'hFFFA, 0, 16'hFFFB, 0);
  endtask

  task automatic t_hold();
    set_cmd(0, 0, 0, 0, 16'h4000, 8'h01, 8'h00, 8'h00, 16'h0, 0, 0);
    bus_hold = 1'b1;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chk(!bus_rd && !seq_done && bus_addr == 16'h4001, "R9 read held",
          {bus_addr, 14'd0, bus_rd, seq_done}, {16'h4001, 16'h0});
      @(negedge clk);
    end
    bus_hold = 1'b0;
    #1;
    chk(bus_rd && seq_done && bus_addr == 16'h4001, "R9 read released",
        {bus_addr, 14'd0, bus_rd, seq_done}, {16'h4001, 16'h3});
    @(negedge clk);
    bus_hold = 1'b1;
    set_cmd(3, 0, 0, 0, 16'h0, 8'h00, 8'h00, 8'h10, 16'h0, 0, 0); run_trace();
    expect_trace("R9 write passes hold", 1, 16'h0110, 2, 16'h0, 0);
    bus_hold = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_abs_idx();
    t_zp();
    t_ptr();
    t_stack();
    t_branch();
    t_vector();
    t_hold();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule